// File: doc/BRIEF.md
# Cross Trigger Channel Matrix

This block links local trigger events to a small set of broadcast channels and back. Each local input trigger carries a programmable channel mask: when the trigger is high, every channel in its mask becomes active. Each local output trigger also carries a mask. When any channel in that mask is active, the output trigger is raised and held until software acknowledges it. Channels can also be driven by software, either persistently (set and clear) or for a single cycle (pulse), and by events arriving from an external channel matrix. A gate chooses which active channels are sent back out to that matrix.

Programming, status readback and software channel injection use a simple 32-bit register bus. Writes take effect on the clock edge that samples them. Reads are combinational from the current state. An identification word reports the number of triggers and channels. A general-purpose control word drives an output port directly. The default build has 8 triggers in each direction and 4 channels.

Top module: `xtrig_matrix`

## Requirements
- R1: After reset, all output triggers and matrix channel outputs are 0, the control word reads 0, every channel mask reads 0, and the gate reads all implemented channels open (0xF for 4 channels).
- R2: Bit 0 of the control word at 0x000 is the global enable. While it is 0, no channel is active, no output trigger is newly raised and the matrix outputs fall to 0. Software channel state written while disabled is retained.
- R3: The channel mask of input trigger n sits at 0x020+4n and that of output trigger n at 0x0A0+4n. Bit c links the trigger to channel c. An input trigger level takes two clock edges to reach a linked output trigger: one edge to sample it, one edge to latch the result.
- R4: A channel is active when any sampled input trigger that maps to it is high, when its software set bit or pulse bit is high, or when the matching matrix input is high. The matrix input reaches a linked output trigger one edge after the edge on which it is sampled.
- R5: Writing 1s to 0x014 sets software channel bits and writing 1s to 0x018 clears them. The bits persist between writes. Reading 0x014 returns the current software channel bits.
- R6: Writing 1s to 0x01C makes those channels active for exactly the one cycle after the write edge. The pulse register always reads 0.
- R7: The matrix output register is loaded on each edge with (active channels AND gate), where the gate sits at 0x140.
- R8: An output trigger stays high until a 1 is written to its bit at 0x010. If a linked channel is active in the same cycle as the acknowledge, the trigger stays high.
- R9: Status words are read-only: 0x130 returns the sampled input triggers, 0x134 the output triggers, 0x138 the raw matrix inputs and 0x13C the matrix output register.
- R10: The identification word at 0xFC8 holds the trigger count in bits [15:8] and the channel count in bits [19:16]. All other bits are 0 (0x00040800 by default).
- R11: The word at 0x144 is read/write and drives the implCtl port directly, one cycle after the write edge.
- R12: Bits beyond the implemented triggers or channels read as 0 and ignore writes. Unmapped or unaligned addresses read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle as a read select |
| trigIn | input | NUM_TRIG | Local input trigger levels |
| trigOut | output | NUM_TRIG | Latched local output triggers |
| chanIn | input | NUM_CHAN | Channel events from the external matrix |
| chanOut | output | NUM_CHAN | Gated channel events to the external matrix |
| implCtl | output | IMPL_W | General-purpose control word |

## Verification
The assertions check four things on every cycle: a disabled unit never raises a new output trigger, a closed gate never lets a channel reach the matrix, an output trigger falls only on an acknowledge, and pulses and software channel bits change only when written. The bench's scenarios cover the rest. These include the exact mapping of each mask bit and the two-edge latency from trigger to output. They also cover set-wins behaviour when an acknowledge meets a live event, and the read values of status, identification and unimplemented bits. A cycle-by-cycle reference model also compares the output triggers, matrix outputs and control word on every clock.

// File: rtl/xtrig_pkg.sv
package xtrig_pkg;

  localparam int MAX_TRIG = 32;

  localparam logic [11:0] OFF_CTRL    = 12'h000;
  localparam logic [11:0] OFF_ACK     = 12'h010;
  localparam logic [11:0] OFF_SET     = 12'h014;
  localparam logic [11:0] OFF_CLR     = 12'h018;
  localparam logic [11:0] OFF_PULSE   = 12'h01C;
  localparam logic [11:0] OFF_INMASK  = 12'h020;
  localparam logic [11:0] OFF_OUTMASK = 12'h0A0;
  localparam logic [11:0] OFF_TIN     = 12'h130;
  localparam logic [11:0] OFF_TOUT    = 12'h134;
  localparam logic [11:0] OFF_CIN     = 12'h138;
  localparam logic [11:0] OFF_COUT    = 12'h13C;
  localparam logic [11:0] OFF_GATE    = 12'h140;
  localparam logic [11:0] OFF_IMPL    = 12'h144;
  localparam logic [11:0] OFF_ID      = 12'hFC8;

  typedef enum logic [3:0] {
    REG_NONE, REG_CTRL, REG_ACK, REG_SET, REG_CLR, REG_PULSE,
    REG_INMASK, REG_OUTMASK, REG_TIN, REG_TOUT, REG_CIN, REG_COUT,
    REG_GATE, REG_IMPL, REG_ID
  } reg_sel_e;

  typedef struct packed {
    logic        wrCtrl;
    logic        wrAck;
    logic        wrSet;
    logic        wrClr;
    logic        wrPulse;
    logic        wrGate;
    logic        wrImpl;
    logic        wrInMask;
    logic        wrOutMask;
    logic [4:0]  idx;
    logic [31:0] data;
    reg_sel_e    rdSel;
  } ctl_strobe_t;

endpackage

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8
) (
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output ctl_strobe_t strobe
);

  localparam logic [11:0] IN_LAST  = OFF_INMASK  + 12'(4 * (NUM_TRIG - 1));
  localparam logic [11:0] OUT_LAST = OFF_OUTMASK + 12'(4 * (NUM_TRIG - 1));

  reg_sel_e   target;
  logic [4:0] maskIdx;
  logic       wrEn;
  logic       rdEn;

  always_comb begin
    target  = REG_NONE;
    maskIdx = '0;
    if (busAddr[1:0] == 2'b00) begin
      if (busAddr >= OFF_INMASK && busAddr <= IN_LAST) begin
        target  = REG_INMASK;
        maskIdx = 5'((busAddr - OFF_INMASK) >> 2);
      end else if (busAddr >= OFF_OUTMASK && busAddr <= OUT_LAST) begin
        target  = REG_OUTMASK;
        maskIdx = 5'((busAddr - OFF_OUTMASK) >> 2);
      end else begin
        case (busAddr)
          OFF_CTRL:  target = REG_CTRL;
          OFF_ACK:   target = REG_ACK;
          OFF_SET:   target = REG_SET;
          OFF_CLR:   target = REG_CLR;
          OFF_PULSE: target = REG_PULSE;
          OFF_TIN:   target = REG_TIN;
          OFF_TOUT:  target = REG_TOUT;
          OFF_CIN:   target = REG_CIN;
          OFF_COUT:  target = REG_COUT;
          OFF_GATE:  target = REG_GATE;
          OFF_IMPL:  target = REG_IMPL;
          OFF_ID:    target = REG_ID;
          default:   target = REG_NONE;
        endcase
      end
    end
  end

  assign wrEn = busSel & busWrite;
  assign rdEn = busSel & ~busWrite;

  always_comb begin
    strobe           = '0;
    strobe.data      = busWdata;
    strobe.idx       = maskIdx;
    strobe.rdSel     = rdEn ? target : REG_NONE;
    strobe.wrCtrl    = wrEn && (target == REG_CTRL);
    strobe.wrAck     = wrEn && (target == REG_ACK);
    strobe.wrSet     = wrEn && (target == REG_SET);
    strobe.wrClr     = wrEn && (target == REG_CLR);
    strobe.wrPulse   = wrEn && (target == REG_PULSE);
    strobe.wrGate    = wrEn && (target == REG_GATE);
    strobe.wrImpl    = wrEn && (target == REG_IMPL);
    strobe.wrInMask  = wrEn && (target == REG_INMASK);
    strobe.wrOutMask = wrEn && (target == REG_OUTMASK);
  end

endmodule

// File: rtl/xtrig_datapath.sv
module xtrig_datapath
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CHAN = 4,
  parameter int IMPL_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctl_strobe_t         strobe,
  input  logic [NUM_TRIG-1:0] trigIn,
  input  logic [NUM_CHAN-1:0] chanIn,
  output logic [NUM_TRIG-1:0] trigOut,
  output logic [NUM_CHAN-1:0] chanOut,
  output logic [IMPL_W-1:0]   implCtl,
  output logic [31:0]         rdData
);

  logic                enQ;
  logic [NUM_CHAN-1:0] appQ;
  logic [NUM_CHAN-1:0] pulseQ;
  logic [NUM_CHAN-1:0] gateQ;
  logic [IMPL_W-1:0]   implQ;
  logic [NUM_TRIG-1:0] tinQ;
  logic [NUM_TRIG-1:0] latchQ;
  logic [NUM_CHAN-1:0] coutQ;

  logic [NUM_CHAN-1:0] inMaskQ   [NUM_TRIG];
  logic [NUM_CHAN-1:0] outMaskQ  [NUM_TRIG];
  logic [NUM_CHAN-1:0] inContrib [NUM_TRIG];
  logic [NUM_TRIG-1:0] trigHit;
  logic [NUM_TRIG-1:0] ackMask;
  logic [NUM_CHAN-1:0] inAgg;
  logic [NUM_CHAN-1:0] chanAct;

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inMaskQ[t]  <= '0;
        outMaskQ[t] <= '0;
      end else begin
        if (strobe.wrInMask && strobe.idx == 5'(t))
          inMaskQ[t] <= strobe.data[NUM_CHAN-1:0];
        if (strobe.wrOutMask && strobe.idx == 5'(t))
          outMaskQ[t] <= strobe.data[NUM_CHAN-1:0];
      end
    end
    assign inContrib[t] = tinQ[t] ? inMaskQ[t] : '0;
    assign trigHit[t]   = |(chanAct & outMaskQ[t]);
  end

  always_comb begin
    inAgg = '0;
    for (int t = 0; t < NUM_TRIG; t++) inAgg = inAgg | inContrib[t];
    chanAct = enQ ? (inAgg | appQ | pulseQ | chanIn) : '0;
  end

  assign ackMask = strobe.wrAck ? strobe.data[NUM_TRIG-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      appQ   <= '0;
      pulseQ <= '0;
      gateQ  <= '1;
      implQ  <= '0;
      tinQ   <= '0;
      latchQ <= '0;
      coutQ  <= '0;
    end else begin
      if (strobe.wrCtrl) enQ <= strobe.data[0];
      if (strobe.wrSet)      appQ <= appQ | strobe.data[NUM_CHAN-1:0];
      else if (strobe.wrClr) appQ <= appQ & ~strobe.data[NUM_CHAN-1:0];
      pulseQ <= strobe.wrPulse ? strobe.data[NUM_CHAN-1:0] : '0;
      if (strobe.wrGate) gateQ <= strobe.data[NUM_CHAN-1:0];
      if (strobe.wrImpl) implQ <= strobe.data[IMPL_W-1:0];
      tinQ   <= trigIn;
      latchQ <= (latchQ & ~ackMask) | trigHit;
      coutQ  <= chanAct & gateQ;
    end
  end

  assign trigOut = latchQ;
  assign chanOut = coutQ;
  assign implCtl = implQ;

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      REG_CTRL:  rdData[0] = enQ;
      REG_SET:   rdData[NUM_CHAN-1:0] = appQ;
      REG_INMASK: begin
        for (int t = 0; t < NUM_TRIG; t++)
          if (strobe.idx == 5'(t)) rdData[NUM_CHAN-1:0] = inMaskQ[t];
      end
      REG_OUTMASK: begin
        for (int t = 0; t < NUM_TRIG; t++)
          if (strobe.idx == 5'(t)) rdData[NUM_CHAN-1:0] = outMaskQ[t];
      end
      REG_TIN:   rdData[NUM_TRIG-1:0] = tinQ;
      REG_TOUT:  rdData[NUM_TRIG-1:0] = latchQ;
      REG_CIN:   rdData[NUM_CHAN-1:0] = chanIn;
      REG_COUT:  rdData[NUM_CHAN-1:0] = coutQ;
      REG_GATE:  rdData[NUM_CHAN-1:0] = gateQ;
      REG_IMPL:  rdData[IMPL_W-1:0]   = implQ;
      REG_ID: begin
        rdData[15:8]  = 8'(NUM_TRIG);
        rdData[19:16] = 4'(NUM_CHAN);
      end
      default:   rdData = '0;
    endcase
  end

  // R2: a disabled unit raises no new output trigger
  a_r2_no_new_trig_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enQ |=> ((latchQ & ~$past(latchQ)) == '0));

  // R7: a closed gate never passes a channel to the matrix
  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((coutQ & ~$past(gateQ)) == '0));

  // R8: output triggers fall only where acknowledged
  a_r8_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(latchQ) & ~latchQ & ~$past(ackMask)) == '0));

  // R6: a pulse lasts one cycle unless rewritten
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    (pulseQ != '0) |=> ((pulseQ == '0) || $past(strobe.wrPulse)));

  // R5: software channel bits only move on set or clear writes
  a_r5_app_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrSet && !strobe.wrClr) |=> $stable(appQ));

endmodule

// File: rtl/xtrig_matrix.sv
module xtrig_matrix
  import xtrig_pkg::*;
#(
  parameter int NUM_TRIG = 8,
  parameter int NUM_CHAN = 4,
  parameter int IMPL_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [11:0]         busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_TRIG-1:0] trigIn,
  output logic [NUM_TRIG-1:0] trigOut,
  input  logic [NUM_CHAN-1:0] chanIn,
  output logic [NUM_CHAN-1:0] chanOut,
  output logic [IMPL_W-1:0]   implCtl
);

  ctl_strobe_t strobe;

  xtrig_ctrl #(.NUM_TRIG(NUM_TRIG)) uCtrl (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .strobe  (strobe)
  );

  xtrig_datapath #(
    .NUM_TRIG(NUM_TRIG),
    .NUM_CHAN(NUM_CHAN),
    .IMPL_W  (IMPL_W)
  ) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .trigIn (trigIn),
    .chanIn (chanIn),
    .trigOut(trigOut),
    .chanOut(chanOut),
    .implCtl(implCtl),
    .rdData (busRdata)
  );

endmodule

// File: tb/xtrig_matrix_test.sv
`timescale 1ns/1ps
module xtrig_matrix_test;

  localparam int NT = 8;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busSel, busWrite;
  logic [11:0]   busAddr;
  logic [31:0]   busWdata, busRdata;
  logic [NT-1:0] trigIn, trigOut;
  logic [NC-1:0] chanIn, chanOut;
  logic [31:0]   implCtl;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  xtrig_matrix uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .trigIn(trigIn), .trigOut(trigOut), .chanIn(chanIn),
    .chanOut(chanOut), .implCtl(implCtl)
  );

  // behavioural reference state
  logic          mEn;
  logic [NC-1:0] mApp, mPulse, mGate, mCout;
  logic [NT-1:0] mTin, mLatch;
  logic [31:0]   mImpl;
  logic [NC-1:0] mIn  [NT];
  logic [NC-1:0] mOut [NT];

  always @(posedge clk or negedge rstN) begin : model
    logic [NC-1:0] ch;
    logic [NT-1:0] hits;
    logic [NT-1:0] ack;
    logic          wr;
    int            a;
    if (!rstN) begin
      mEn <= 0; mApp <= 0; mPulse <= 0; mGate <= '1; mCout <= 0;
      mTin <= 0; mLatch <= 0; mImpl <= 0;
      for (int t = 0; t < NT; t++) begin mIn[t] <= 0; mOut[t] <= 0; end
    end else begin
      ch = 0;
      for (int t = 0; t < NT; t++) if (mTin[t]) ch = ch | mIn[t];
      ch = mEn ? (ch | mApp | mPulse | chanIn) : '0;
      for (int t = 0; t < NT; t++) hits[t] = |(ch & mOut[t]);
      wr  = busSel && busWrite;
      a   = int'(busAddr);
      ack = (wr && a == 'h010) ? busWdata[NT-1:0] : '0;
      mLatch <= (mLatch & ~ack) | hits;
      mCout  <= ch & mGate;
      mTin   <= trigIn;
      mPulse <= (wr && a == 'h01C) ? busWdata[NC-1:0] : '0;
      if (wr) begin
        if (a == 'h000) mEn <= busWdata[0];
        if (a == 'h014) mApp <= mApp | busWdata[NC-1:0];
        if (a == 'h018) mApp <= mApp & ~busWdata[NC-1:0];
        if (a == 'h140) mGate <= busWdata[NC-1:0];
        if (a == 'h144) mImpl <= busWdata;
        if (a >= 'h020 && a < 'h020 + 4*NT && a % 4 == 0) mIn[(a - 'h020) / 4] <= busWdata[NC-1:0];
        if (a >= 'h0A0 && a < 'h0A0 + 4*NT && a % 4 == 0) mOut[(a - 'h0A0) / 4] <= busWdata[NC-1:0];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check("R8 trigOut vs model", 32'(trigOut), 32'(mLatch));
      check("R7 chanOut vs model", 32'(chanOut), 32'(mCout));
      check("R11 implCtl vs model", implCtl, mImpl);
    end
  end

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 0; busWrite = 0; busAddr = '0; busWdata = '0;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    busSel = 1; busWrite = 0; busAddr = a;
    #1;
    check(tag, busRdata, exp);
    @(negedge clk);
    busSel = 0; busAddr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rstN = 0; busSel = 0; busWrite = 0; busAddr = 0; busWdata = 0;
    trigIn = 0; chanIn = 0;
    idle(3);
    check("R1 reset trigOut", 32'(trigOut), 0);
    check("R1 reset chanOut", 32'(chanOut), 0);
    rstN = 1;
    idle(1);
    rdChk("R1 ctrl after reset", 12'h000, 0);
    rdChk("R1 gate after reset", 12'h140, 32'hF);
    rdChk("R1 mask after reset", 12'h0A4, 0);
    rdChk("R10 identification", 12'hFC8, 32'h0004_0800);

    // R3: input 0 -> channel 0 -> output 3
    wrReg(12'h020, 32'h1);
    wrReg(12'h0AC, 32'h1);
    wrReg(12'h000, 32'h1);
    rdChk("R3 input mask readback", 12'h020, 32'h1);
    trigIn = 8'h01;
    idle(1);
    trigIn = 8'h00;
    check("R3 not yet latched after one edge", 32'(trigOut), 0);
    idle(1);
    check("R3 latched after two edges", 32'(trigOut), 32'h08);
    idle(2);
    rdChk("R9 output status", 12'h134, 32'h08);
    wrReg(12'h010, 32'h08);
    rdChk("R8 acknowledged", 12'h134, 0);

    // R8: acknowledge while event still live -> stays set
    trigIn = 8'h01;
    idle(3);
    rdChk("R9 input status", 12'h130, 32'h01);
    wrReg(12'h010, 32'h08);
    rdChk("R8 set wins over ack", 12'h134, 32'h08);
    trigIn = 0;
    idle(3);
    wrReg(12'h010, 32'h08);
    check("R8 cleared after event gone", 32'(trigOut), 0);

    // R9 / R4: matrix inputs
    chanIn = 4'hA;
    idle(2);
    rdChk("R9 matrix input status", 12'h138, 32'hA);
    rdChk("R9 matrix output status", 12'h13C, 32'hA);
    chanIn = 0;
    idle(2);
    wrReg(12'h0BC, 32'h8);
    chanIn = 4'h8;
    idle(2);
    check("R4 matrix input raises output 7", 32'(trigOut), 32'h80);
    chanIn = 0;
    idle(2);
    wrReg(12'h010, 32'h80);

    // R6: pulse channel 1 onto output 1
    wrReg(12'h0A4, 32'h2);
    wrReg(12'h01C, 32'h2);
    check("R6 pulse not yet on matrix", 32'(chanOut), 0);
    idle(1);
    check("R6 pulse on matrix for one cycle", 32'(chanOut), 32'h2);
    idle(1);
    check("R6 pulse gone", 32'(chanOut), 0);
    check("R6 pulse latched output 1", 32'(trigOut), 32'h02);
    rdChk("R6 pulse reads zero", 12'h01C, 0);
    wrReg(12'h010, 32'h02);

    // R5: persistent set/clear on channel 2 -> output 5
    wrReg(12'h0B4, 32'h4);
    wrReg(12'h014, 32'h4);
    rdChk("R5 set readback", 12'h014, 32'h4);
    idle(4);
    check("R5 channel held", 32'(chanOut), 32'h4);
    check("R5 output 5 raised", 32'(trigOut), 32'h20);
    wrReg(12'h018, 32'h4);
    rdChk("R5 cleared readback", 12'h014, 0);
    idle(2);
    wrReg(12'h010, 32'h20);
    idle(2);
    check("R5 output stays low after clear", 32'(trigOut), 0);

    // R7: gate masks matrix output
    wrReg(12'h140, 32'h5);
    wrReg(12'h014, 32'hF);
    idle(2);
    check("R7 gated matrix output", 32'(chanOut), 32'h5);
    wrReg(12'h018, 32'hF);
    idle(2);
    wrReg(12'h010, 32'hFF);
    wrReg(12'h140, 32'hF);
    idle(1);
    check("R7 outputs cleared", 32'(trigOut), 0);

    // R2: disabled unit
    wrReg(12'h000, 32'h0);
    wrReg(12'h014, 32'h1);
    trigIn = 8'h01; chanIn = 4'hF;
    idle(4);
    check("R2 no output triggers when off", 32'(trigOut), 0);
    check("R2 no matrix output when off", 32'(chanOut), 0);
    rdChk("R2 software bits retained", 12'h014, 32'h1);
    trigIn = 0; chanIn = 0;
    wrReg(12'h018, 32'h1);

    // R11: implementation control
    wrReg(12'h144, 32'hA5A5_0001);
    check("R11 implCtl port", implCtl, 32'hA5A5_0001);
    rdChk("R11 readback", 12'h144, 32'hA5A5_0001);

    // R12: unimplemented bits and addresses
    wrReg(12'h140, 32'hFFFF_FFFF);
    rdChk("R12 gate upper bits", 12'h140, 32'hF);
    wrReg(12'h000, 32'hFFFF_FFFE);
    rdChk("R12 ctrl only bit 0", 12'h000, 0);
    wrReg(12'h040, 32'hF);
    rdChk("R12 mask beyond last trigger", 12'h040, 0);
    rdChk("R12 last mask untouched", 12'h03C, 0);
    wrReg(12'h021, 32'hF);
    rdChk("R12 unaligned read", 12'h021, 0);
    rdChk("R12 unaligned write ignored", 12'h020, 32'h1);
    wrReg(12'h134, 32'hFF);
    rdChk("R9 status is read-only", 12'h134, 0);

    idle(2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule